// File: doc/BRIEF.md
# Dithered-Resolution PWM Generator

This block drives one PWM pin from a 24-bit setpoint while using only an 8-bit frame counter. The top byte of the setpoint is the base duty of each 256-cycle frame. The low 16 bits are a fraction. At every frame boundary a first-order sigma-delta stage adds that fraction to a 16-bit error register. When the addition carries, the next frame runs one count longer. Over many frames the average duty therefore resolves the full 24-bit code. The carry pattern of an accumulate-and-overflow stage spaces the longer frames as evenly as the ratio allows.

A 4-bit resolution-limit input forces a chosen number of the fraction's low bits to zero before they reach the accumulator. A coarser fraction gives a coarser average step. It also puts an upper bound on the gap between two correction frames, which places a floor under the lowest frequency the corrections can produce. The downstream analog filter can then be sized for that floor. Both inputs are taken only at a frame boundary. A one-cycle strobe marks the first cycle of each frame.

Top module: `sdpwm_top`

## Requirements
- R1: While the synchronous reset is asserted, and for the whole first frame after it is released, the output is low and the frame strobe is low. The reset clears the frame counter and the error register.
- R2: A frame lasts 256 clock cycles. The frame strobe is high for exactly one cycle, the first cycle of each frame, which is the cycle after the counter passes from 255 to 0.
- R3: Within a frame, the output is high for the first D cycles and low for the rest, where D is the effective duty of that frame.
- R4: The effective duty is setpoint bits [23:16], plus 1 when the accumulator carried at the boundary that opened the frame.
- R5: At each boundary, the 16-bit error register adds the masked fraction, taken from setpoint bits [15:0], modulo 2^16. The carry-out of that addition selects the +1 for the frame that follows.
- R6: A constant setpoint of 0x800100 gives 255 frames of duty 0x80 and exactly 1 frame of duty 0x81 in every 256 consecutive frames.
- R7: Correction frames are spread evenly. A constant fraction of 0x4000, starting from a known error value, gives a +1 frame every 4th frame exactly.
- R8: A resolution-limit value N (0 to 15) forces fraction bits [N-1:0] to zero before accumulation. With fraction 0x7FFF and N = 15, no frame is ever corrected.
- R9: A base duty of 0xFF with a carry holds the output high for all 256 cycles of the frame. It never wraps to duty 0.
- R10: The setpoint and resolution limit are sampled only in the last cycle of a frame. A change made earlier in a frame does not alter that frame. A change made in its last cycle takes effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| setpoint | input | 24 | Base duty in [23:16], fraction in [15:0] |
| resLimit | input | 4 | Number of fraction LSBs forced to zero |
| pwmOut | output | 1 | PWM output |
| frameStrobe | output | 1 | One-cycle pulse in the first cycle of each frame |

## Verification
Sampling a new setpoint and applying a carried correction both happen in the last cycle of a frame. The delicate case is a setpoint change that lands in exactly that cycle. The bench drives new settings either at the start of a frame or in its final cycle. For each case it checks that the frame in progress keeps the old duty and that the next frame's high count matches an arithmetic model of the error register fed with the new value. A second collision, a carry that meets a base duty of 0xFF, is provoked with setpoints 0xFF8000 and 0x12FFFF/0xFFxxxx-style fractions. It is judged by whether the frame stays high for all 256 cycles.

// File: rtl/sdpwm_pkg.sv
package sdpwm_pkg;

  // Strobes from the frame control to the datapath
  typedef struct packed {
    logic frameLoad;   // last cycle of frame: sample inputs, step accumulator
    logic frameLast;   // same instant, used by datapath to latch duty
  } sdpwmCtrl_t;

endpackage

// File: rtl/sdpwm_ctrl.sv
module sdpwm_ctrl
  import sdpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] frameCnt,
  output sdpwmCtrl_t       ctrlBus,
  output logic             frameStrobe
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic atEnd;

  assign atEnd = (frameCnt == CNT_MAX);

  always_comb begin
    ctrlBus.frameLoad = atEnd;
    ctrlBus.frameLast = atEnd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frameCnt    <= '0;
      frameStrobe <= 1'b0;
    end else begin
      frameCnt    <= frameCnt + 1'b1;
      frameStrobe <= atEnd;
    end
  end

endmodule

// File: rtl/sdpwm_accum.sv
module sdpwm_accum #(
  parameter int FRAC_W = 16,
  parameter int RES_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stepEn,
  input  logic [FRAC_W-1:0] fracIn,
  input  logic [RES_W-1:0]  resLimit,
  output logic              carryOut
);

  logic [FRAC_W-1:0] fracMask;
  logic [FRAC_W-1:0] fracKept;
  logic [FRAC_W-1:0] errAcc;
  logic [FRAC_W-1:0] errNext;

  // Bits below resLimit are cleared; the rest pass unchanged
  always_comb begin
    int lim;
    lim = int'(resLimit);
    for (int i = 0; i < FRAC_W; i++) begin
      fracMask[i] = (i >= lim);
    end
  end

  assign fracKept = fracIn & fracMask;
  assign {carryOut, errNext} = {1'b0, errAcc} + {1'b0, fracKept};

  always_ff @(posedge clk) begin
    if (rst) begin
      errAcc <= '0;
    end else if (stepEn) begin
      errAcc <= errNext;
    end
  end

endmodule

// File: rtl/sdpwm_dp.sv
module sdpwm_dp
  import sdpwm_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  sdpwmCtrl_t        ctrlBus,
  input  logic [DUTY_W-1:0] frameCnt,
  input  logic [DUTY_W-1:0] baseDuty,
  input  logic              bumpIn,
  output logic [DUTY_W-1:0] dutyReg,
  output logic              dutyFull,
  output logic              pwmOut
);

  logic [DUTY_W:0] dutySum;

  // One extra bit catches 0xFF + 1, which means high for the whole frame
  assign dutySum = {1'b0, baseDuty} + {{DUTY_W{1'b0}}, bumpIn};

  always_ff @(posedge clk) begin
    if (rst) begin
      dutyReg  <= '0;
      dutyFull <= 1'b0;
    end else if (ctrlBus.frameLast) begin
      dutyReg  <= dutySum[DUTY_W-1:0];
      dutyFull <= dutySum[DUTY_W];
    end
  end

  assign pwmOut = dutyFull | (frameCnt < dutyReg);

endmodule

// File: rtl/sdpwm_top.sv
module sdpwm_top
  import sdpwm_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int FRAC_W = 16,
  parameter int RES_W  = 4,
  localparam int SP_W  = DUTY_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SP_W-1:0]  setpoint,
  input  logic [RES_W-1:0] resLimit,
  output logic             pwmOut,
  output logic             frameStrobe
);

  logic [DUTY_W-1:0] frameCnt;
  sdpwmCtrl_t        ctrlBus;
  logic              bump;
  logic [DUTY_W-1:0] dutyReg;
  logic              dutyFull;

  sdpwm_ctrl #(.CNT_W(DUTY_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frameCnt   (frameCnt),
    .ctrlBus    (ctrlBus),
    .frameStrobe(frameStrobe)
  );

  sdpwm_accum #(.FRAC_W(FRAC_W), .RES_W(RES_W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .stepEn  (ctrlBus.frameLoad),
    .fracIn  (setpoint[FRAC_W-1:0]),
    .resLimit(resLimit),
    .carryOut(bump)
  );

  sdpwm_dp #(.DUTY_W(DUTY_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrlBus (ctrlBus),
    .frameCnt(frameCnt),
    .baseDuty(setpoint[SP_W-1:FRAC_W]),
    .bumpIn  (bump),
    .dutyReg (dutyReg),
    .dutyFull(dutyFull),
    .pwmOut  (pwmOut)
  );

endmodule

// File: rtl/sdpwm_chk.sv
module sdpwm_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             frameStrobe,
  input logic             pwmOut,
  input logic [CNT_W-1:0] frameCnt,
  input logic [CNT_W-1:0] dutyReg,
  input logic             dutyFull,
  input logic             frameLoad
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (frameCnt == '0) && !frameStrobe && !dutyFull);

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    frameStrobe |=> !frameStrobe);

  // R2
  strobe_follows_load_chk: assert property (@(posedge clk) disable iff (rst)
    frameLoad |=> frameStrobe);

  // R2
  strobe_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    frameStrobe |-> (frameCnt == '0));

  // R10
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frameLoad |=> ($stable(dutyReg) && $stable(dutyFull)));

  // R9
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    dutyFull |-> pwmOut);

endmodule

bind sdpwm_top sdpwm_chk #(.CNT_W(DUTY_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frameStrobe(frameStrobe),
  .pwmOut     (pwmOut),
  .frameCnt   (frameCnt),
  .dutyReg    (dutyReg),
  .dutyFull   (dutyFull),
  .frameLoad  (ctrlBus.frameLoad)
);

// File: tb/sdpwm_top_tb.sv
module sdpwm_top_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] setpoint = 24'h0;
  logic [3:0]  resLimit = 4'd0;
  logic        pwmOut;
  logic        frameStrobe;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [23:0] prevSp;
  logic [3:0]  prevRes;
  logic [15:0] mAcc;
  bit          lastBump;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdpwm_top u_dut (
    .clk        (clk),
    .rst        (rst),
    .setpoint   (setpoint),
    .resLimit   (resLimit),
    .pwmOut     (pwmOut),
    .frameStrobe(frameStrobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called on the negedge of a strobe cycle; measures one whole frame
  task automatic doFrame(input logic [23:0] sp, input logic [3:0] rs,
                         input bit late, input string req);
    logic [16:0] sum;
    logic [15:0] msk;
    int expHigh, hi, extraStrobe;
    bit contiguous, seenLow;
    check(frameStrobe == 1'b1, "R2", int'(frameStrobe), 1);
    msk = 16'hFFFF << prevRes;
    sum = {1'b0, mAcc} + {1'b0, prevSp[15:0] & msk};
    mAcc = sum[15:0];
    lastBump = sum[16];
    expHigh = int'(prevSp[23:16]) + int'(sum[16]);
    if (expHigh > 256) expHigh = 256;
    if (!late) begin
      setpoint = sp;
      resLimit = rs;
    end
    hi = 0; extraStrobe = 0; contiguous = 1'b1; seenLow = 1'b0;
    for (int i = 0; i < 256; i++) begin
      if (late && i == 255) begin
        setpoint = sp;
        resLimit = rs;
      end
      if (pwmOut) begin
        hi++;
        if (seenLow) contiguous = 1'b0;
      end else begin
        seenLow = 1'b1;
      end
      if (i > 0 && frameStrobe) extraStrobe++;
      @(negedge clk);
    end
    check(hi == expHigh, req, hi, expHigh);
    check(contiguous, "R3", int'(contiguous), 1);
    check(extraStrobe == 0, "R2", extraStrobe, 0);
    prevSp = sp;
    prevRes = rs;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int bumps, lowFrames, period;
    setpoint = 24'hFF8000;
    resLimit = 4'd0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    check(pwmOut == 1'b0, "R1", int'(pwmOut), 0);
    check(frameStrobe == 1'b0, "R1", int'(frameStrobe), 0);
    rst = 1'b0;
    bumps = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwmOut || frameStrobe) bumps++;
      @(negedge clk);
    end
    // R1: first frame after reset stays low, no strobe
    check(bumps == 0, "R1", bumps, 0);
    prevSp = 24'hFF8000; prevRes = 4'd0; mAcc = 16'h0;

    // R9: 0xFF8000 gives 255 then 256 (saturated, no wrap)
    doFrame(24'hFF8000, 4'd0, 1'b0, "R9");
    doFrame(24'h800100, 4'd0, 1'b0, "R9");

    // R6: 0x800100 over 256 frames -> one 0x81 frame
    bumps = 0; lowFrames = 0;
    for (int k = 0; k < 256; k++) begin
      doFrame(24'h800100, 4'd0, 1'b0, "R6");
      if (lastBump) bumps++; else lowFrames++;
    end
    check(bumps == 1, "R6", bumps, 1);
    check(lowFrames == 255, "R6", lowFrames, 255);

    // R7: fraction 0x4000 bumps every 4th frame
    doFrame(24'h404000, 4'd0, 1'b0, "R4");
    period = 0; bumps = 0;
    for (int k = 1; k <= 8; k++) begin
      doFrame(24'h404000, 4'd0, 1'b0, "R7");
      if (lastBump) begin
        bumps++;
        check(k % 4 == 0, "R7", k, 4 * bumps);
      end
    end
    check(bumps == 2, "R7", bumps, 2);

    // R8: N=15 zeroes fraction 0x7FFF -> never corrected
    doFrame(24'h407FFF, 4'd15, 1'b0, "R8");
    bumps = 0;
    for (int k = 0; k < 6; k++) begin
      doFrame(24'h407FFF, 4'd15, 1'b0, "R8");
      if (lastBump) bumps++;
    end
    check(bumps == 0, "R8", bumps, 0);

    // R8/R5: sweep every resolution limit against the model
    for (int n = 0; n < 16; n++) begin
      for (int k = 0; k < 4; k++) begin
        doFrame(24'h12FFFF, 4'(n), 1'b0, "R8");
      end
    end

    // R5/R9: nearly full fraction at top duty
    for (int k = 0; k < 5; k++) doFrame(24'hFFFFFF, 4'd0, 1'b0, "R5");

    // R4: zero code
    for (int k = 0; k < 3; k++) doFrame(24'h000000, 4'd0, 1'b0, "R4");

    // R10: change in last cycle applies next frame; early change does not alter current
    doFrame(24'h300000, 4'd0, 1'b1, "R10");
    doFrame(24'h500000, 4'd0, 1'b1, "R10");
    doFrame(24'h20C000, 4'd3, 1'b0, "R10");
    doFrame(24'h20C000, 4'd3, 1'b1, "R10");
    doFrame(24'h000000, 4'd0, 1'b0, "R10");
    doFrame(24'h000000, 4'd0, 1'b0, "R4");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule